// File: doc/BRIEF.md
# Variable-Length Instruction Byte Buffer

This block sits between a word-wide instruction fetch path and a decoder that handles instructions of varying length. Each instruction is a one-byte opcode followed by zero or more operand bytes. The fetch side pushes aligned 4-byte words whenever there is space. The decoder looks at a window of up to 5 bytes at the head of the queue. It is told how many of those bytes are valid, and it reports back how many it used in that cycle. This lets fetch and decode run at their own pace.

Storage is a 12-byte circular queue with byte granularity. Writes always add four bytes at the tail. Reads retire between zero and five bytes from the head, and the head wraps around the end of the store. When a branch is taken, a flush empties the queue in a single cycle.

Top module: `vlen_byte_buffer`

## Requirements
- R1: After reset the queue is empty: `rdCount` is 0 and `wrReady` is 1.
- R2: `wrReady` is high exactly when the occupancy is 8 or less, that is, when at least 4 of the 12 bytes are free.
- R3: A write is accepted at a rising edge when `wrValid` and `wrReady` are both high and `flush` is low. It appends four bytes in the order `wrData[7:0]`, `wrData[15:8]`, `wrData[23:16]`, `wrData[31:24]`.
- R4: `rdCount` equals the smaller of 5 and the current occupancy.
- R5: Window byte k, `rdBytes[8k+7:8k]`, holds the k-th oldest stored byte for every k below `rdCount`. Byte 0 is the oldest.
- R6: A consume of n bytes removes the n oldest bytes at the next edge. The head advances by n modulo 12, so byte order is kept across the wrap point.
- R7: When a write and a consume of n bytes happen in the same cycle, the occupancy changes by 4 minus n.
- R8: `flush` empties the queue in one cycle. A write offered in the same cycle is dropped, and the consume count is ignored.
- R9: A `consumeCnt` larger than `rdCount` removes exactly `rdCount` bytes.
- R10: A write offered while `wrReady` is low is ignored and leaves the stored bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Fetch side offers a 4-byte word |
| wrReady | output | 1 | At least 4 bytes are free |
| wrData | input | 32 | Word to append, lowest byte first |
| flush | input | 1 | Empty the queue, for example on a taken branch |
| rdBytes | output | 40 | Five-byte window, head byte in bits 7:0 |
| rdCount | output | 3 | Number of valid window bytes, 0 to 5 |
| consumeCnt | input | 3 | Bytes the decoder retires this cycle |

## Verification
Two pairs of functions can fall in the same cycle: a word append together with a variable consume, and a flush together with an offered write. The bench provokes both pairs with directed steps, for example a consume across the wrap point while a word is written. It also runs a long pseudo-random phase where `wrValid`, `consumeCnt` values up to 7 and occasional flushes overlap freely. A byte-queue model in the bench judges every cycle on the window contents, the valid count and the ready flag. The checker also follows the occupancy arithmetic for concurrent writes and consumes.

// File: rtl/vlen_byte_buffer_pkg.sv
package vlen_byte_buffer_pkg;

  // Strobes the control path hands to the byte store each cycle.
  typedef struct packed {
    logic wrEn;   // append one word at the tail
    logic clear;  // queue emptied this cycle
  } bufStrobes_t;

  // Circular index: base + offset folded into [0, depth).
  function automatic int unsigned wrapIdx(int unsigned base, int unsigned off,
                                          int unsigned depth);
    int unsigned sum;
    sum = base + off;
    while (sum >= depth) sum = sum - depth;
    return sum;
  endfunction

endpackage

// File: rtl/vlen_byte_buffer_ctrl.sv
module vlen_byte_buffer_ctrl
  import vlen_byte_buffer_pkg::*;
#(
  parameter int DEPTH      = 12,
  parameter int WORD_BYTES = 4,
  parameter int WIN_BYTES  = 5,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int CNT_W = $clog2(WIN_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              flush,
  input  logic [CNT_W-1:0]  consumeCnt,
  output logic              wrReady,
  output logic [CNT_W-1:0]  rdCount,
  output logic [PTR_W-1:0]  headPtr,
  output logic [PTR_W-1:0]  tailPtr,
  output logic [OCC_W-1:0]  occ,
  output bufStrobes_t       strobes
);

  localparam logic [OCC_W-1:0] WIN_OCC   = OCC_W'(WIN_BYTES);
  localparam logic [OCC_W-1:0] READY_MAX = OCC_W'(DEPTH - WORD_BYTES);
  localparam logic [OCC_W-1:0] WORD_OCC  = OCC_W'(WORD_BYTES);

  logic [CNT_W-1:0] effConsume;
  logic             accept;
  logic [OCC_W-1:0] occNext;

  always_comb begin
    wrReady    = (occ <= READY_MAX);
    rdCount    = (occ > WIN_OCC) ? CNT_W'(WIN_BYTES) : CNT_W'(occ);
    effConsume = (consumeCnt > rdCount) ? rdCount : consumeCnt;
    accept     = wrValid && wrReady && !flush;
    occNext    = occ + (accept ? WORD_OCC : '0) - OCC_W'(effConsume);
    strobes.wrEn  = accept;
    strobes.clear = flush;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      occ     <= '0;
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      occ     <= occNext;
      headPtr <= PTR_W'(wrapIdx(int'(headPtr), int'(effConsume), DEPTH));
      if (accept)
        tailPtr <= PTR_W'(wrapIdx(int'(tailPtr), WORD_BYTES, DEPTH));
    end
  end

endmodule

// File: rtl/vlen_byte_buffer_dp.sv
module vlen_byte_buffer_dp
  import vlen_byte_buffer_pkg::*;
#(
  parameter int DEPTH      = 12,
  parameter int WORD_BYTES = 4,
  parameter int WIN_BYTES  = 5,
  parameter int BYTE_W     = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  bufStrobes_t                   strobes,
  input  logic [PTR_W-1:0]              headPtr,
  input  logic [PTR_W-1:0]              tailPtr,
  input  logic [WORD_BYTES*BYTE_W-1:0]  wrData,
  output logic [WIN_BYTES*BYTE_W-1:0]   rdBytes
);

  logic [BYTE_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrIdx [WORD_BYTES];
  logic [PTR_W-1:0]  rdIdx [WIN_BYTES];

  for (genvar w = 0; w < WORD_BYTES; w++) begin : g_wrIdx
    assign wrIdx[w] = PTR_W'(wrapIdx(int'(tailPtr), w, DEPTH));
  end

  for (genvar k = 0; k < WIN_BYTES; k++) begin : g_window
    assign rdIdx[k] = PTR_W'(wrapIdx(int'(headPtr), k, DEPTH));
    assign rdBytes[k*BYTE_W +: BYTE_W] = store[rdIdx[k]];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) begin
      for (int e = 0; e < DEPTH; e++) store[e] <= '0;
    end else if (strobes.wrEn) begin
      for (int w = 0; w < WORD_BYTES; w++)
        store[wrIdx[w]] <= wrData[w*BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/vlen_byte_buffer.sv
module vlen_byte_buffer
  import vlen_byte_buffer_pkg::*;
#(
  parameter int DEPTH      = 12,
  parameter int WORD_BYTES = 4,
  parameter int WIN_BYTES  = 5,
  parameter int BYTE_W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int CNT_W = $clog2(WIN_BYTES + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrValid,
  output logic                         wrReady,
  input  logic [WORD_BYTES*BYTE_W-1:0] wrData,
  input  logic                         flush,
  output logic [WIN_BYTES*BYTE_W-1:0]  rdBytes,
  output logic [CNT_W-1:0]             rdCount,
  input  logic [CNT_W-1:0]             consumeCnt
);

  bufStrobes_t      strobes;
  logic [PTR_W-1:0] headPtr;
  logic [PTR_W-1:0] tailPtr;
  logic [OCC_W-1:0] occ;

  vlen_byte_buffer_ctrl #(
    .DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES), .WIN_BYTES(WIN_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .flush(flush),
    .consumeCnt(consumeCnt), .wrReady(wrReady), .rdCount(rdCount),
    .headPtr(headPtr), .tailPtr(tailPtr), .occ(occ), .strobes(strobes)
  );

  vlen_byte_buffer_dp #(
    .DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES), .WIN_BYTES(WIN_BYTES), .BYTE_W(BYTE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .headPtr(headPtr),
    .tailPtr(tailPtr), .wrData(wrData), .rdBytes(rdBytes)
  );

endmodule

// File: rtl/vlen_byte_buffer_checker.sv
module vlen_byte_buffer_checker #(
  parameter int DEPTH      = 12,
  parameter int WORD_BYTES = 4,
  parameter int WIN_BYTES  = 5,
  parameter int BYTE_W     = 8,
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int CNT_W = $clog2(WIN_BYTES + 1)
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        wrValid,
  input logic                        wrReady,
  input logic                        flush,
  input logic [CNT_W-1:0]            consumeCnt,
  input logic [CNT_W-1:0]            rdCount,
  input logic [WIN_BYTES*BYTE_W-1:0] rdBytes,
  input logic [OCC_W-1:0]            occ
);

  int used;
  assign used = (int'(consumeCnt) > int'(rdCount)) ? int'(rdCount) : int'(consumeCnt);

  // R2: a full-enough queue always presents a complete window
  assert_full_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    !wrReady |-> int'(rdCount) == WIN_BYTES);

  // R4: the valid count never exceeds the window or the stored bytes
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    int'(rdCount) <= WIN_BYTES && int'(rdCount) <= int'(occ));

  // R8: a flush leaves an empty, writable queue
  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> rdCount == '0 && wrReady);

  // R7: a concurrent write and consume change occupancy by 4 minus the consumed count
  assert_concurrent_occ_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady && !flush) |=>
      int'(occ) == int'($past(occ)) + WORD_BYTES - $past(used));

  // R10: an offered write that is refused never grows the queue
  assert_refused_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!wrReady && !flush) |=> int'(occ) <= int'($past(occ)));

  // R6: with no write, consume or flush the window holds still
  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!(wrValid && wrReady) && consumeCnt == '0 && !flush) |=>
      $stable(rdBytes) && $stable(rdCount));

endmodule

bind vlen_byte_buffer vlen_byte_buffer_checker #(
  .DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES), .WIN_BYTES(WIN_BYTES), .BYTE_W(BYTE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady), .flush(flush),
  .consumeCnt(consumeCnt), .rdCount(rdCount), .rdBytes(rdBytes), .occ(occ)
);

// File: tb/vlen_byte_buffer_tb.sv
module vlen_byte_buffer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic        wrReady;
  logic [31:0] wrData = '0;
  logic        flush = 1'b0;
  logic [39:0] rdBytes;
  logic [2:0]  rdCount;
  logic [2:0]  consumeCnt = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] model[$];   // scoreboard: expected stored bytes, oldest first

  always #4 clk = ~clk;   // 125 MHz

  vlen_byte_buffer u_dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady),
    .wrData(wrData), .flush(flush), .rdBytes(rdBytes), .rdCount(rdCount),
    .consumeCnt(consumeCnt)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: compare the ports with the scoreboard contents.
  task automatic monitor(string ctx);
    int expCnt = (model.size() > 5) ? 5 : model.size();
    bit expRdy = (model.size() <= 8);
    check(int'(rdCount) == expCnt, {"R4 count ", ctx}, int'(rdCount), expCnt);
    check(wrReady == expRdy, {"R2 ready ", ctx}, int'(wrReady), int'(expRdy));
    for (int k = 0; k < expCnt; k++)
      check(rdBytes[8*k +: 8] == model[k], {"R5 byte ", ctx},
            int'(rdBytes[8*k +: 8]), int'(model[k]));
  endtask

  // Driver: check current state, apply one cycle of stimulus, update the scoreboard.
  task automatic step(bit v, logic [31:0] d, bit f, int n, string ctx);
    int avail;
    int eff;
    bit rdy;
    @(negedge clk);
    monitor(ctx);
    avail = (model.size() > 5) ? 5 : model.size();
    eff   = (n > avail) ? avail : n;          // R9 clamp
    rdy   = (model.size() <= 8);
    wrValid = v; wrData = d; flush = f; consumeCnt = 3'(n);
    if (f) begin
      model.delete();                         // R8: write and consume dropped
    end else begin
      for (int i = 0; i < eff; i++) void'(model.pop_front());   // R6
      if (v && rdy)                           // R3 / R10
        for (int b = 0; b < 4; b++) model.push_back(d[8*b +: 8]);
    end
    @(posedge clk);
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check(rdCount == 3'd0, "R1 count after reset", int'(rdCount), 0);
    check(wrReady == 1'b1, "R1 ready after reset", int'(wrReady), 1);

    step(1, 32'h04030201, 0, 0, "R3 first word");
    step(1, 32'h08070605, 0, 0, "R3 second word");
    step(1, 32'h0C0B0A09, 0, 0, "R3 third word to occupancy 12");
    step(1, 32'hDEADBEEF, 0, 0, "R10 write while full");
    step(0, 0, 0, 5, "R6 consume five");
    step(0, 0, 0, 3, "R6 consume three");
    step(1, 32'h14131211, 0, 2, "R7 write plus consume");
    step(1, 32'h18171615, 0, 4, "R7 write plus consume across wrap");
    step(0, 0, 0, 1, "R6 consume one");
    step(0, 0, 0, 5, "R6 consume five wrapped");
    step(0, 0, 0, 7, "R9 oversize consume");
    step(0, 0, 0, 0, "R9 empty after clamp");
    step(1, 32'h24232221, 0, 5, "R9 consume on empty with write");
    step(1, 32'h28272625, 1, 2, "R8 flush with write");
    step(1, 32'h34333231, 0, 0, "R8 refill after flush");
    step(0, 0, 0, 0, "R3 idle");

    for (int c = 0; c < 600; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], {lfsr, ~lfsr ^ 16'(c)}, (lfsr[7:3] == 5'd0),
           int'(lfsr[6:4]), "R7 random mix");
    end
    step(0, 0, 0, 0, "final");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule